// File: doc/BRIEF.md
# Rotating-Parity Stripe Mapper and XOR Engine

This block serves a disk array controller that spreads data over `NDISK` member disks with one parity block per stripe row. The parity block moves to a different member on every row. The mapper channel takes a logical block number and returns three values one cycle later: the member disk that holds the block, the stripe row, and the member that holds that row's parity. Each row carries `NDISK-1` data blocks. Data blocks fill a row starting at the member just after the parity member and wrap around modulo `NDISK`. As a result, consecutive logical blocks always land on different disks.

The word channel is a streaming XOR engine with two modes. In parity mode it folds the `NDISK-1` data words of a stripe into one parity word. In rebuild mode each word is tagged with its member index, and the command names a failed member. Words tagged with the failed index are accepted but do not contribute. After `NDISK-1` surviving words, which include the parity word, the engine emits the regenerated word of the failed member. Both channels use valid/ready handshakes, and each has a single registered output stage.

Top module: `raid_stripe_engine`

## Requirements
- R1: The reported row equals the logical block number divided by `NDISK-1`, with the remainder discarded.
- R2: The reported parity member equals `(NDISK-1) - (row mod NDISK)`.
- R3: The reported data member equals `(parity + 1 + (lba mod (NDISK-1))) mod NDISK`. It is never the parity member and is always below `NDISK`.
- R4: A mapping result is valid in the cycle after its request is accepted. While `res_ready` is low, the result holds unchanged and `map_ready` stays low.
- R5: In parity mode (`word_rebuild` = 0), the output word is the XOR of the `NDISK-1` words accepted since the last start-of-stripe word. It becomes valid in the cycle after the last of those words is accepted, and not earlier.
- R6: A word accepted with `word_sos` = 1 discards all words accumulated before it, whether or not that earlier stripe was complete.
- R7: In rebuild mode (`word_rebuild` = 1), a word whose `word_disk` equals `word_fail` is accepted but has no effect on the result or on the word count. The result is the XOR of the first `NDISK-1` other words.
- R8: While `xo_valid` is high and `xo_ready` is low, `xo_data` holds unchanged and `word_ready` stays low.
- R9: After reset, `res_valid` and `xo_valid` are low, and both `map_ready` and `word_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_valid | input | 1 | Mapping request valid |
| map_ready | output | 1 | Mapping request accepted when high |
| map_lba | input | LBA_W | Logical block number |
| res_valid | output | 1 | Mapping result valid |
| res_ready | input | 1 | Consumer takes mapping result |
| res_disk | output | DISK_W | Member holding the data block |
| res_row | output | LBA_W | Stripe row |
| res_parity | output | DISK_W | Member holding the row's parity |
| word_valid | input | 1 | Data word valid |
| word_ready | output | 1 | Data word accepted when high |
| word_data | input | WORD_W | Data or parity word |
| word_disk | input | DISK_W | Member index the word came from |
| word_sos | input | 1 | First word of a stripe; clears the accumulator |
| word_rebuild | input | 1 | 0 = build parity, 1 = rebuild a failed member |
| word_fail | input | DISK_W | Failed member index (rebuild mode) |
| xo_valid | output | 1 | Result word valid |
| xo_ready | input | 1 | Consumer takes result word |
| xo_data | output | WORD_W | Parity or regenerated word |

## Verification
A bad rotation or remainder in the mapper shows up on `res_disk` or `res_parity` in the very next cycle after acceptance. Rows are chosen so that the row index modulo `NDISK` covers every parity position, including the wrap at multiples of `NDISK`. A wrong word count in the XOR engine shows up as `xo_valid` rising one word early or one word late. Stale accumulator contents or a failed member's word that leaks into the sum appear as a corrupted `xo_data` on the first result after the faulty word.

// File: rtl/raid_pkg.sv
package raid_pkg;

    typedef enum logic {
        XM_PARITY  = 1'b0,
        XM_REBUILD = 1'b1
    } xor_mode_e;

endpackage

// File: rtl/stripe_mapper.sv
module stripe_mapper #(
    parameter int NDISK  = 5,
    parameter int LBA_W  = 16,
    parameter int DISK_W = $clog2(NDISK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_valid,
    output logic              map_ready,
    input  logic [LBA_W-1:0]  map_lba,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DISK_W-1:0] res_disk,
    output logic [LBA_W-1:0]  res_row,
    output logic [DISK_W-1:0] res_parity
);
    localparam int DATA_N = NDISK - 1;

    typedef struct packed {
        logic              valid;
        logic [DISK_W-1:0] disk;
        logic [LBA_W-1:0]  row;
        logic [DISK_W-1:0] par;
    } map_st_t;

    map_st_t st_d, st_q;

    logic [LBA_W-1:0]  row_w;
    logic [LBA_W-1:0]  slot_w;
    logic [LBA_W-1:0]  rmod_w;
    logic [DISK_W-1:0] par_w;
    logic [DISK_W:0]   sum_w;
    logic [DISK_W-1:0] disk_w;
    logic              fire;

    assign map_ready = !st_q.valid || res_ready;
    assign fire      = map_valid && map_ready;

    always_comb begin
        row_w  = map_lba / LBA_W'(DATA_N);
        slot_w = map_lba % LBA_W'(DATA_N);
        rmod_w = row_w % LBA_W'(NDISK);
        par_w  = DISK_W'(NDISK - 1) - DISK_W'(rmod_w);
        sum_w  = {1'b0, par_w} + (DISK_W+1)'(1) + (DISK_W+1)'(slot_w);
        if (sum_w >= (DISK_W+1)'(NDISK)) begin
            disk_w = DISK_W'(sum_w - (DISK_W+1)'(NDISK));
        end else begin
            disk_w = DISK_W'(sum_w);
        end

        st_d = st_q;
        if (st_q.valid && res_ready) begin
            st_d.valid = 1'b0;
        end
        if (fire) begin
            st_d.valid = 1'b1;
            st_d.disk  = disk_w;
            st_d.row   = row_w;
            st_d.par   = par_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.valid;
    assign res_disk   = st_q.disk;
    assign res_row    = st_q.row;
    assign res_parity = st_q.par;

    AST_DATA_NOT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_disk != res_parity)); // R3
    AST_DISK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_disk < DISK_W'(NDISK))); // R3
    AST_MAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && map_ready) |=> res_valid); // R4
    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_disk)
                                       && $stable(res_row) && $stable(res_parity))); // R4
endmodule

// File: rtl/xor_engine.sv
module xor_engine
    import raid_pkg::*;
#(
    parameter int NDISK  = 5,
    parameter int WORD_W = 32,
    parameter int DISK_W = $clog2(NDISK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic [DISK_W-1:0] word_disk,
    input  logic              word_sos,
    input  logic              word_rebuild,
    input  logic [DISK_W-1:0] word_fail,
    output logic              xo_valid,
    input  logic              xo_ready,
    output logic [WORD_W-1:0] xo_data
);
    localparam int CNT_W  = $clog2(NDISK);
    localparam int NEED_N = NDISK - 1;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic              out_valid;
        logic [WORD_W-1:0] out_data;
    } xe_st_t;

    xe_st_t st_d, st_q;

    xor_mode_e         mode;
    logic              fire;
    logic              skip;
    logic [WORD_W-1:0] base_acc;
    logic [CNT_W-1:0]  base_cnt;
    logic [WORD_W-1:0] new_acc;
    logic [CNT_W-1:0]  new_cnt;

    assign mode       = xor_mode_e'(word_rebuild);
    assign word_ready = !st_q.out_valid || xo_ready;
    assign fire       = word_valid && word_ready;
    assign skip       = (mode == XM_REBUILD) && (word_disk == word_fail);

    always_comb begin
        base_acc = word_sos ? '0 : st_q.acc;
        base_cnt = word_sos ? '0 : st_q.cnt;
        if (skip) begin
            new_acc = base_acc;
            new_cnt = base_cnt;
        end else begin
            new_acc = base_acc ^ word_data;
            new_cnt = base_cnt + CNT_W'(1);
        end

        st_d = st_q;
        if (st_q.out_valid && xo_ready) begin
            st_d.out_valid = 1'b0;
        end
        if (fire) begin
            if (new_cnt == CNT_W'(NEED_N)) begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = new_acc;
                st_d.acc       = '0;
                st_d.cnt       = '0;
            end else begin
                st_d.acc = new_acc;
                st_d.cnt = new_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xo_valid = st_q.out_valid;
    assign xo_data  = st_q.out_data;

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(NEED_N)); // R5
    AST_SKIP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && skip && !word_sos) |=> (st_q.acc == $past(st_q.acc)
                                         && st_q.cnt == $past(st_q.cnt))); // R7
    AST_XO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_valid && !xo_ready) |=> (xo_valid && $stable(xo_data))); // R8
    AST_XO_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_valid && !xo_ready) |-> !word_ready); // R8
endmodule

// File: rtl/raid_stripe_engine.sv
module raid_stripe_engine #(
    parameter int NDISK  = 5,
    parameter int LBA_W  = 16,
    parameter int WORD_W = 32,
    parameter int DISK_W = $clog2(NDISK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_valid,
    output logic              map_ready,
    input  logic [LBA_W-1:0]  map_lba,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DISK_W-1:0] res_disk,
    output logic [LBA_W-1:0]  res_row,
    output logic [DISK_W-1:0] res_parity,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic [DISK_W-1:0] word_disk,
    input  logic              word_sos,
    input  logic              word_rebuild,
    input  logic [DISK_W-1:0] word_fail,
    output logic              xo_valid,
    input  logic              xo_ready,
    output logic [WORD_W-1:0] xo_data
);
    stripe_mapper #(
        .NDISK (NDISK),
        .LBA_W (LBA_W),
        .DISK_W(DISK_W)
    ) u_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_valid (map_valid),
        .map_ready (map_ready),
        .map_lba   (map_lba),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_disk  (res_disk),
        .res_row   (res_row),
        .res_parity(res_parity)
    );

    xor_engine #(
        .NDISK (NDISK),
        .WORD_W(WORD_W),
        .DISK_W(DISK_W)
    ) u_xor (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_ready  (word_ready),
        .word_data   (word_data),
        .word_disk   (word_disk),
        .word_sos    (word_sos),
        .word_rebuild(word_rebuild),
        .word_fail   (word_fail),
        .xo_valid    (xo_valid),
        .xo_ready    (xo_ready),
        .xo_data     (xo_data)
    );
endmodule

// File: tb/raid_stripe_engine_bench.sv
module raid_stripe_engine_bench;
    localparam int NDISK  = 5;
    localparam int LBA_W  = 16;
    localparam int WORD_W = 32;
    localparam int DISK_W = $clog2(NDISK);
    localparam int NVEC   = 12;

    // lba, expected disk, expected row, expected parity (NDISK = 5)
    localparam int VEC_LBA [NVEC] = '{0, 3, 4, 5, 7, 8, 13, 19, 20, 23, 42, 1000};
    localparam int VEC_DSK [NVEC] = '{0, 3, 4, 0, 2, 3, 3,  4,  0,  3,  2,  0};
    localparam int VEC_ROW [NVEC] = '{0, 0, 1, 1, 1, 2, 3,  4,  5,  5,  10, 250};
    localparam int VEC_PAR [NVEC] = '{4, 4, 3, 3, 3, 2, 1,  0,  4,  4,  4,  4};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              map_valid = 1'b0;
    logic              map_ready;
    logic [LBA_W-1:0]  map_lba = '0;
    logic              res_valid;
    logic              res_ready = 1'b1;
    logic [DISK_W-1:0] res_disk;
    logic [LBA_W-1:0]  res_row;
    logic [DISK_W-1:0] res_parity;
    logic              word_valid = 1'b0;
    logic              word_ready;
    logic [WORD_W-1:0] word_data = '0;
    logic [DISK_W-1:0] word_disk = '0;
    logic              word_sos = 1'b0;
    logic              word_rebuild = 1'b0;
    logic [DISK_W-1:0] word_fail = '0;
    logic              xo_valid;
    logic              xo_ready = 1'b1;
    logic [WORD_W-1:0] xo_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    raid_stripe_engine #(
        .NDISK(NDISK), .LBA_W(LBA_W), .WORD_W(WORD_W)
    ) u_raid_stripe_engine (
        .clk(clk), .rst_n(rst_n),
        .map_valid(map_valid), .map_ready(map_ready), .map_lba(map_lba),
        .res_valid(res_valid), .res_ready(res_ready), .res_disk(res_disk),
        .res_row(res_row), .res_parity(res_parity),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .word_disk(word_disk), .word_sos(word_sos), .word_rebuild(word_rebuild),
        .word_fail(word_fail), .xo_valid(xo_valid), .xo_ready(xo_ready),
        .xo_data(xo_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives a request at a falling edge; returns at the falling edge after acceptance
    task automatic map_req(input int lba);
        @(negedge clk);
        map_valid = 1'b1;
        map_lba   = LBA_W'(lba);
        while (!map_ready) @(negedge clk);
        @(negedge clk);
        map_valid = 1'b0;
    endtask

    task automatic send_word(input logic [WORD_W-1:0] d, input int dsk, input logic sos,
                             input logic reb, input int fail);
        @(negedge clk);
        word_valid   = 1'b1;
        word_data    = d;
        word_disk    = DISK_W'(dsk);
        word_sos     = sos;
        word_rebuild = reb;
        word_fail    = DISK_W'(fail);
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        word_sos   = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [WORD_W-1:0] exp_w;
        logic [WORD_W-1:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 res_valid", res_valid, 0);
        check("R9 xo_valid", xo_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 map_ready", map_ready, 1);
        check("R9 word_ready", word_ready, 1);

        // mapping table: R1, R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            map_req(VEC_LBA[i]);
            check("R4 res_valid", res_valid, 1);
            check("R1 row", res_row, VEC_ROW[i]);
            check("R2 parity", res_parity, VEC_PAR[i]);
            check("R3 disk", res_disk, VEC_DSK[i]);
        end
        @(negedge clk);
        check("R4 drained", res_valid, 0);

        // R4: result held under back-pressure
        res_ready = 1'b0;
        map_req(5);
        map_valid = 1'b1;
        map_lba   = LBA_W'(19);
        repeat (3) begin
            @(negedge clk);
            check("R4 hold valid", res_valid, 1);
            check("R4 hold disk", res_disk, 0);
            check("R4 hold row", res_row, 1);
            check("R4 map_ready low", map_ready, 0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        map_valid = 1'b0;
        check("R4 next result disk", res_disk, 4);
        check("R4 next result parity", res_parity, 0);
        @(negedge clk);

        // R5: parity of four data words
        send_word(32'h1111_0001, 0, 1'b1, 1'b0, 0);
        send_word(32'h2222_0010, 1, 1'b0, 1'b0, 0);
        send_word(32'h4444_0100, 2, 1'b0, 1'b0, 0);
        check("R5 not early", xo_valid, 0);
        send_word(32'h8888_1000, 3, 1'b0, 1'b0, 0);
        check("R5 valid", xo_valid, 1);
        check("R5 parity", xo_data, 32'hFFFF_1111);
        @(negedge clk);

        // R6: start-of-stripe discards a partial stripe
        send_word(32'hDEAD_BEEF, 0, 1'b1, 1'b0, 0);
        send_word(32'h0BAD_F00D, 1, 1'b0, 1'b0, 0);
        send_word(32'h0000_00A5, 0, 1'b1, 1'b0, 0);
        send_word(32'h0000_5A00, 1, 1'b0, 1'b0, 0);
        send_word(32'h00C3_0000, 2, 1'b0, 1'b0, 0);
        check("R6 not early", xo_valid, 0);
        send_word(32'h3C00_0000, 3, 1'b0, 1'b0, 0);
        check("R6 valid", xo_valid, 1);
        check("R6 data", xo_data, 32'h3CC3_5AA5);
        @(negedge clk);

        // R7: rebuild member 2; its word is ignored
        exp_w = 32'h1357_9BDF ^ 32'h2468_ACE0 ^ 32'h0F0F_0F0F ^ 32'hA5A5_5A5A;
        send_word(32'h1357_9BDF, 0, 1'b1, 1'b1, 2);
        send_word(32'h2468_ACE0, 1, 1'b0, 1'b1, 2);
        send_word(32'hFFFF_FFFF, 2, 1'b0, 1'b1, 2);
        send_word(32'h0F0F_0F0F, 3, 1'b0, 1'b1, 2);
        check("R7 not early", xo_valid, 0);
        send_word(32'hA5A5_5A5A, 4, 1'b0, 1'b1, 2);
        check("R7 valid", xo_valid, 1);
        check("R7 rebuilt", xo_data, exp_w);
        @(negedge clk);

        // R7: failed member arrives first with sos
        exp_w = 32'h0000_0001 ^ 32'h0000_0002 ^ 32'h0000_0004 ^ 32'h0000_0008;
        send_word(32'h7777_7777, 4, 1'b1, 1'b1, 4);
        send_word(32'h0000_0001, 0, 1'b0, 1'b1, 4);
        send_word(32'h0000_0002, 1, 1'b0, 1'b1, 4);
        send_word(32'h0000_0004, 2, 1'b0, 1'b1, 4);
        check("R7 ignored word not counted", xo_valid, 0);
        send_word(32'h0000_0008, 3, 1'b0, 1'b1, 4);
        check("R7 valid first-skip", xo_valid, 1);
        check("R7 data first-skip", xo_data, exp_w);
        @(negedge clk);

        // R8: output held while consumer stalls
        xo_ready = 1'b0;
        send_word(32'h0000_0F00, 0, 1'b1, 1'b0, 0);
        send_word(32'h0000_00F0, 1, 1'b0, 1'b0, 0);
        send_word(32'h0000_000F, 2, 1'b0, 1'b0, 0);
        send_word(32'h0000_F000, 3, 1'b0, 1'b0, 0);
        held = xo_data;
        repeat (3) begin
            @(negedge clk);
            check("R8 hold valid", xo_valid, 1);
            check("R8 hold data", xo_data, held);
            check("R8 word_ready low", word_ready, 0);
        end
        check("R8 data value", held, 32'h0000_FFFF);
        xo_ready = 1'b1;
        @(negedge clk);
        check("R8 drained", xo_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule